// File: doc/BRIEF.md
# PHY-Side Link Interface Sequencer

This block sits on the physical-layer side of the narrow parallel interface between a serial-bus transceiver and its link-layer controller. It owns a 2-bit control bus and a 4-bit data bus and uses them for three kinds of traffic. It hands 16-bit status words to the link two bits per cycle. It forwards received packet symbols behind a short preamble and a speed code. It also hands the interface to the link when arbitration is won and takes it back when the link lets go.

The status source raises a request with a word and holds it until the block reports completion. The receive path delivers a data-on flag and a symbol strobe from the cable decoder. The arbiter pulses a won flag. The link's own control code comes back in while the link owns the interface. Every output is registered. In every cycle where the link owns the interface, a single enable tells the pad logic to float both buses.

Top module: `lnk_if_seq`

## Requirements
- R1: While reset is held and in the first cycle after it, the block drives control code 00 (idle) and data 0000 with the drive enable high.
- R2: A status transfer starts only from a driven idle cycle. Control code 01 is then held for 8 consecutive cycles. In cycle i (i = 0..7), d_o[3] carries word bit 2i, d_o[2] carries word bit 2i+1, and d_o[1:0] are 0.
- R3: If rx_on is seen during a status transfer, the next cycle drives code 10 with data 1111 and the status is dropped without a done pulse. Once the receive ends, the whole word is sent again starting from pair 0.
- R4: After the 8th pair, the block drives idle and pulses stat_done for one cycle. The next status transfer starts no earlier than two cycles after that, so at least one idle cycle always separates two transfers.
- R5: When rx_on is seen while idle, the next cycle drives code 10 with data 1111. This preamble repeats each cycle until the first symbol strobe.
- R6: The cycle after the first strobed symbol carries the speed code with control 10: data 0100 when rx_fast is high and 0000 when it is low. Each strobed symbol then follows in order, one cycle later than its input.
- R7: Control returns to 00 in the cycle after the last symbol is output, that is, when the strobe has stopped.
- R8: If rx_on falls during the preamble before any symbol, the next cycle drives idle.
- R9: After arb_won, the block drives code 11 for one cycle, then 00 for one cycle, and then lowers drv_en.
- R10: drv_en stays low for the whole of the link's ownership, whatever rx_on does. A link code 00 seen before the link's first hold (01) or transmit (10) is not taken as a release.
- R11: Once the link has driven hold or transmit, its first 00 is a release. drv_en stays low for one more cycle, and the block drives idle from the cycle after that.
- R12: If the link drives hold (01) directly after transmit (10), the block re-issues code 11 two cycles later, with no arb_won, and then follows the R9 sequence again.
- R13: From idle, rx_on takes precedence over a pending grant, and a grant over a status request. An arb_won seen while the receive path is busy is remembered and served later.
- R14: Symbol lanes: for a fast packet all four bits of rx_sym pass to d_o. For a slow packet rx_sym[3:2] go to d_o[3:2] and d_o[1:0] are driven 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock |
| rst_n | input | 1 | Active-low synchronous reset |
| stat_req | input | 1 | A status word is waiting |
| stat_word | input | STAT_W | Status word to transfer |
| stat_done | output | 1 | One-cycle pulse when a status word has gone out whole |
| rx_on | input | 1 | Data-on state seen on the cable |
| rx_sym_vld | input | 1 | Strobe for a received symbol |
| rx_sym | input | 4 | Received symbol |
| rx_fast | input | 1 | Packet speed: 1 fast, 0 slow; taken with the first symbol |
| arb_won | input | 1 | Pulse: arbitration won for the link |
| lnk_ctl_i | input | 2 | Control code driven by the link |
| ctl_o | output | 2 | Control code driven toward the link |
| d_o | output | 4 | Data driven toward the link |
| drv_en | output | 1 | Drive enable for ctl_o and d_o |

## Verification
The bench goes after the corner cases where the order of events matters. A receive is started two pairs into a status word. A design that resumes mid-word, or pulses done on the abort, shows the wrong pair or a spurious done. The bench also raises a link idle before the link's first hold. A sequencer that treats any 00 as a release would reclaim the bus while the link still owns it. Hold after transmit must bring a fresh grant without arb_won, and a single-cycle preamble abort must drop straight to idle. Slow packets must clear the two unused lanes. A grant that arrives alongside a receive must be kept, not lost.

// File: rtl/lnkseq_pkg.sv
package lnkseq_pkg;
  localparam int LANES = 4;

  typedef enum logic [1:0] {
    PC_IDLE  = 2'b00,
    PC_STAT  = 2'b01,
    PC_RECV  = 2'b10,
    PC_GRANT = 2'b11
  } phy_code_e;

  typedef enum logic [1:0] {
    LK_IDLE = 2'b00,
    LK_HOLD = 2'b01,
    LK_XMIT = 2'b10,
    LK_RSVD = 2'b11
  } lnk_code_e;

  typedef enum logic [3:0] {
    SQ_IDLE, SQ_STAT, SQ_RXPRE, SQ_RXDAT,
    SQ_GNT, SQ_GNTI, SQ_LINK, SQ_REL, SQ_REGNT
  } seq_st_e;

  // speed marker placed on the data lanes after the preamble
  function automatic logic [LANES-1:0] spd_code(input logic fast);
    return fast ? 4'b0100 : 4'b0000;
  endfunction

  // slow packets use only the two upper lanes
  function automatic logic [LANES-1:0] lane_fmt(input logic [LANES-1:0] sym,
                                                input logic fast);
    return fast ? sym : {sym[LANES-1 -: 2], {(LANES-2){1'b0}}};
  endfunction
endpackage

// File: rtl/lis_stat_unit.sv
module lis_stat_unit #(
  parameter int STAT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              adv,
  input  logic              fin,
  input  logic              abort,
  input  logic [STAT_W-1:0] word_i,
  output logic [1:0]        first_pair,
  output logic [1:0]        next_pair,
  output logic              last,
  output logic              done_q
);
  localparam int NPAIR = STAT_W / 2;
  localparam int IW    = (NPAIR > 1) ? $clog2(NPAIR) : 1;

  logic [IW-1:0]     idx;
  logic [STAT_W-1:0] word_q;

  function automatic logic [1:0] pair_at(input logic [STAT_W-1:0] w,
                                         input logic [IW-1:0] i);
    int b;
    b = 2 * int'(i);
    return {w[b], w[b+1]};
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx    <= '0;
      word_q <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= fin;
      if (start) begin
        idx    <= '0;
        word_q <= word_i;
      end else if (adv) begin
        idx <= idx + 1'b1;
      end else if (abort || fin) begin
        idx <= '0;
      end
    end
  end

  assign first_pair = pair_at(word_i, '0);
  assign next_pair  = pair_at(word_q, idx + 1'b1);
  assign last       = (idx == IW'(NPAIR - 1));

  // R2
  stat_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adv |=> (idx == IW'($past(idx) + 1'b1)));
endmodule

// File: rtl/lis_rx_unit.sv
module lis_rx_unit import lnkseq_pkg::*; (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sym_vld_i,
  input  logic [LANES-1:0] sym_i,
  input  logic             fast_i,
  input  logic             take_spd,
  output logic [LANES-1:0] sym_q,
  output logic             vld_q,
  output logic             fast_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sym_q  <= '0;
      vld_q  <= 1'b0;
      fast_q <= 1'b0;
    end else begin
      sym_q <= sym_i;
      vld_q <= sym_vld_i;
      if (take_spd) fast_q <= fast_i;
    end
  end
endmodule

// File: rtl/lis_own_track.sv
module lis_own_track import lnkseq_pkg::*; (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       active,
  input  logic [1:0] lnk_ctl_i,
  output logic       release_evt,
  output logic       rehold_evt
);
  logic busy;
  logic last_xmit;

  always_ff @(posedge clk) begin
    if (!rst_n || !active) begin
      busy      <= 1'b0;
      last_xmit <= 1'b0;
    end else begin
      busy      <= busy || (lnk_ctl_i == LK_HOLD) || (lnk_ctl_i == LK_XMIT);
      last_xmit <= (lnk_ctl_i == LK_XMIT);
    end
  end

  assign release_evt = active && busy && (lnk_ctl_i == LK_IDLE);
  assign rehold_evt  = active && last_xmit && (lnk_ctl_i == LK_HOLD);

  // R12
  rehold_after_xmit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rehold_evt |-> ($past(lnk_ctl_i) == LK_XMIT));
endmodule

// File: rtl/lnk_if_seq.sv
module lnk_if_seq import lnkseq_pkg::*; #(
  parameter int STAT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stat_req,
  input  logic [STAT_W-1:0] stat_word,
  output logic              stat_done,
  input  logic              rx_on,
  input  logic              rx_sym_vld,
  input  logic [LANES-1:0]  rx_sym,
  input  logic              rx_fast,
  input  logic              arb_won,
  input  logic [1:0]        lnk_ctl_i,
  output logic [1:0]        ctl_o,
  output logic [LANES-1:0]  d_o,
  output logic              drv_en
);
  seq_st_e st, st_n;
  logic [1:0]       ctl_n;
  logic [LANES-1:0] d_n;
  logic             en_n;
  logic             gnt_pend;

  // named internal events
  logic stat_start, stat_adv, stat_fin, stat_abort;
  logic rx_begin, rx_first;
  logic grant_idle, grant_again;
  logic release_evt, rehold_evt;
  logic link_active;

  logic [1:0]       st_first, st_next;
  logic             st_last, done_q;
  logic [LANES-1:0] sym_q;
  logic             vld_q, fast_q;

  lis_stat_unit #(.STAT_W(STAT_W)) u_stat (
    .clk(clk), .rst_n(rst_n), .start(stat_start), .adv(stat_adv),
    .fin(stat_fin), .abort(stat_abort), .word_i(stat_word),
    .first_pair(st_first), .next_pair(st_next), .last(st_last), .done_q(done_q)
  );

  lis_rx_unit u_rx (
    .clk(clk), .rst_n(rst_n), .sym_vld_i(rx_sym_vld), .sym_i(rx_sym),
    .fast_i(rx_fast), .take_spd(rx_first),
    .sym_q(sym_q), .vld_q(vld_q), .fast_q(fast_q)
  );

  assign link_active = (st == SQ_LINK);

  lis_own_track u_own (
    .clk(clk), .rst_n(rst_n), .active(link_active), .lnk_ctl_i(lnk_ctl_i),
    .release_evt(release_evt), .rehold_evt(rehold_evt)
  );

  always_comb begin
    st_n        = st;
    ctl_n       = PC_IDLE;
    d_n         = '0;
    en_n        = 1'b1;
    stat_start  = 1'b0;
    stat_adv    = 1'b0;
    stat_fin    = 1'b0;
    stat_abort  = 1'b0;
    rx_begin    = 1'b0;
    rx_first    = 1'b0;
    grant_idle  = 1'b0;
    grant_again = 1'b0;
    case (st)
      SQ_IDLE: begin
        if (rx_on) begin
          st_n = SQ_RXPRE; ctl_n = PC_RECV; d_n = '1; rx_begin = 1'b1;
        end else if (gnt_pend || arb_won) begin
          st_n = SQ_GNT; ctl_n = PC_GRANT; grant_idle = 1'b1;
        end else if (stat_req && !done_q) begin
          st_n = SQ_STAT; ctl_n = PC_STAT; d_n = {st_first, 2'b00};
          stat_start = 1'b1;
        end
      end
      SQ_STAT: begin
        if (rx_on) begin
          st_n = SQ_RXPRE; ctl_n = PC_RECV; d_n = '1;
          rx_begin = 1'b1; stat_abort = 1'b1;
        end else if (st_last) begin
          st_n = SQ_IDLE; stat_fin = 1'b1;
        end else begin
          ctl_n = PC_STAT; d_n = {st_next, 2'b00}; stat_adv = 1'b1;
        end
      end
      SQ_RXPRE: begin
        if (!rx_on) begin
          st_n = SQ_IDLE;
        end else if (rx_sym_vld) begin
          st_n = SQ_RXDAT; ctl_n = PC_RECV; d_n = spd_code(rx_fast);
          rx_first = 1'b1;
        end else begin
          ctl_n = PC_RECV; d_n = '1;
        end
      end
      SQ_RXDAT: begin
        if (vld_q) begin
          ctl_n = PC_RECV; d_n = lane_fmt(sym_q, fast_q);
        end else begin
          st_n = SQ_IDLE;
        end
      end
      SQ_GNT:   st_n = SQ_GNTI;
      SQ_GNTI: begin
        st_n = SQ_LINK; en_n = 1'b0;
      end
      SQ_LINK: begin
        en_n = 1'b0;
        if (release_evt)     st_n = SQ_REL;
        else if (rehold_evt) st_n = SQ_REGNT;
      end
      SQ_REL:   st_n = SQ_IDLE;
      SQ_REGNT: begin
        st_n = SQ_GNT; ctl_n = PC_GRANT; grant_again = 1'b1;
      end
      default:  st_n = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= SQ_IDLE;
      ctl_o    <= PC_IDLE;
      d_o      <= '0;
      drv_en   <= 1'b1;
      gnt_pend <= 1'b0;
    end else begin
      st       <= st_n;
      ctl_o    <= ctl_n;
      d_o      <= d_n;
      drv_en   <= en_n;
      gnt_pend <= (gnt_pend || arb_won) && !grant_idle;
    end
  end

  assign stat_done = done_q;

  // R2
  stat_from_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stat_start |-> (drv_en && ctl_o == PC_IDLE));

  // R4
  stat_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (drv_en && $past(ctl_o) == PC_STAT && ctl_o != PC_STAT) |=> (ctl_o != PC_STAT));

  // R5
  rx_preamble_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_begin |=> (drv_en && ctl_o == PC_RECV && d_o == '1));

  // R7
  rx_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == SQ_RXDAT && !vld_q) |=> (ctl_o == PC_IDLE));

  // R9
  grant_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (drv_en && ctl_o == PC_GRANT) |=> (drv_en && ctl_o == PC_IDLE) ##1 !drv_en);

  // R10
  link_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == SQ_LINK || st == SQ_REL || st == SQ_REGNT) |-> !drv_en);

  // R11
  release_resume_chk: assert property (@(posedge clk) disable iff (!rst_n)
    release_evt |=> !drv_en ##1 (drv_en && ctl_o == PC_IDLE));

  // R12
  regrant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rehold_evt |=> !drv_en ##1 (drv_en && ctl_o == PC_GRANT));
endmodule

// File: tb/test_lnk_if_seq.sv
`timescale 1ns/1ps
module test_lnk_if_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        stat_req = 1'b0;
  logic [15:0] stat_word = '0;
  logic        stat_done;
  logic        rx_on = 1'b0;
  logic        rx_sym_vld = 1'b0;
  logic [3:0]  rx_sym = '0;
  logic        rx_fast = 1'b0;
  logic        arb_won = 1'b0;
  logic [1:0]  lnk_ctl = 2'b00;
  logic [1:0]  ctl_o;
  logic [3:0]  d_o;
  logic        drv_en;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  typedef struct {
    logic [1:0] ctl;
    logic [3:0] d;
    logic       en;
    logic       done;
    logic       chk_cd;
    string      tag;
    int         due;
  } exp_t;
  exp_t sb[$];

  always #4 clk = ~clk;

  lnk_if_seq i_lnk_if_seq (
    .clk(clk), .rst_n(rst_n), .stat_req(stat_req), .stat_word(stat_word),
    .stat_done(stat_done), .rx_on(rx_on), .rx_sym_vld(rx_sym_vld),
    .rx_sym(rx_sym), .rx_fast(rx_fast), .arb_won(arb_won),
    .lnk_ctl_i(lnk_ctl), .ctl_o(ctl_o), .d_o(d_o), .drv_en(drv_en)
  );

  always @(posedge clk) cyc <= cyc + 1;

  // monitor: compare outputs against queued expectations
  always @(negedge clk) begin
    while (sb.size() > 0 && sb[0].due == cyc) begin
      exp_t e;
      e = sb.pop_front();
      checks++;
      if (e.chk_cd) begin
        if (ctl_o !== e.ctl || d_o !== e.d || drv_en !== e.en || stat_done !== e.done) begin
          fails++;
          $display("FAIL %s: ctl=%b d=%h en=%b done=%b expected ctl=%b d=%h en=%b done=%b",
                   e.tag, ctl_o, d_o, drv_en, stat_done, e.ctl, e.d, e.en, e.done);
        end
      end else if (drv_en !== e.en) begin
        fails++;
        $display("FAIL %s: en=%b expected en=%b", e.tag, drv_en, e.en);
      end
    end
  end

  function automatic logic [1:0] bench_pair(input logic [15:0] w, input int i);
    logic [15:0] s;
    s = w >> (2 * i);
    return {s[0], s[1]};
  endfunction

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic push(input logic [1:0] c, input logic [3:0] dd, input logic en,
                      input logic dn, input logic cd, input string tag);
    exp_t e;
    e.ctl = c; e.d = dd; e.en = en; e.done = dn; e.chk_cd = cd; e.tag = tag;
    e.due = cyc + 1;
    sb.push_back(e);
    step();
  endtask

  task automatic exp_cd(input logic [1:0] c, input logic [3:0] dd, input string tag);
    push(c, dd, 1'b1, 1'b0, 1'b1, tag);
  endtask

  task automatic exp_float(input string tag);
    push(2'b00, 4'h0, 1'b0, 1'b0, 1'b0, tag);
  endtask

  task automatic exp_done(input string tag);
    push(2'b00, 4'h0, 1'b1, 1'b1, 1'b1, tag);
  endtask

  task automatic send_pairs(input logic [15:0] w, input int from, input string tag);
    for (int i = from; i < 8; i++) exp_cd(2'b01, {bench_pair(w, i), 2'b00}, tag);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    summary();
    $finish;
  end

  initial begin
    // R1 reset state
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;
    if (ctl_o !== 2'b00 || d_o !== 4'h0 || drv_en !== 1'b1) begin
      fails++;
      $display("FAIL R1: ctl=%b d=%h en=%b expected ctl=00 d=0 en=1", ctl_o, d_o, drv_en);
    end
    @(posedge clk); #1;
    rst_n = 1'b1;
    exp_cd(2'b00, 4'h0, "R1 first cycle");

    // R2 / R4: two status words back to back
    stat_word = 16'hA5C3; stat_req = 1'b1;
    send_pairs(16'hA5C3, 0, "R2 status pairs");
    stat_word = 16'h3C96;
    exp_done("R4 done pulse");
    exp_cd(2'b00, 4'h0, "R4 idle gap");
    send_pairs(16'h3C96, 0, "R4 second word");
    exp_done("R4 second done");
    stat_req = 1'b0;
    exp_cd(2'b00, 4'h0, "R4 idle after");

    // R3 pre-emption plus slow receive (R5 R6 R14 R7)
    stat_word = 16'h1234; stat_req = 1'b1;
    exp_cd(2'b01, {bench_pair(16'h1234, 0), 2'b00}, "R2 pair0");
    exp_cd(2'b01, {bench_pair(16'h1234, 1), 2'b00}, "R2 pair1");
    exp_cd(2'b01, {bench_pair(16'h1234, 2), 2'b00}, "R2 pair2");
    rx_on = 1'b1;
    exp_cd(2'b10, 4'hF, "R3 preempt");
    exp_cd(2'b10, 4'hF, "R5 preamble held");
    rx_sym_vld = 1'b1; rx_sym = 4'hB; rx_fast = 1'b0;
    exp_cd(2'b10, 4'h0, "R6 slow speed code");
    rx_sym = 4'h7;
    exp_cd(2'b10, 4'h8, "R14 slow lanes");
    rx_sym_vld = 1'b0; rx_on = 1'b0;
    exp_cd(2'b10, 4'h4, "R14 slow lanes zeroed");
    exp_cd(2'b00, 4'h0, "R7 end of packet");
    send_pairs(16'h1234, 0, "R3 retry from pair0");
    exp_done("R3 retry done");
    stat_req = 1'b0;
    step();

    // fast receive
    rx_on = 1'b1;
    exp_cd(2'b10, 4'hF, "R5 preamble");
    rx_sym_vld = 1'b1; rx_sym = 4'h9; rx_fast = 1'b1;
    exp_cd(2'b10, 4'h4, "R6 fast speed code");
    rx_sym = 4'h3;
    exp_cd(2'b10, 4'h9, "R14 fast lanes");
    rx_sym_vld = 1'b0; rx_on = 1'b0;
    exp_cd(2'b10, 4'h3, "R6 symbol order");
    exp_cd(2'b00, 4'h0, "R7 end fast");

    // R8 data-on vanishes in preamble
    rx_on = 1'b1;
    exp_cd(2'b10, 4'hF, "R5 preamble");
    rx_on = 1'b0;
    exp_cd(2'b00, 4'h0, "R8 abort to idle");
    exp_cd(2'b00, 4'h0, "R8 stays idle");

    // R9 R10 R11 grant and release
    arb_won = 1'b1;
    exp_cd(2'b11, 4'h0, "R9 grant code");
    arb_won = 1'b0;
    exp_cd(2'b00, 4'h0, "R9 idle after grant");
    exp_float("R9 float");
    exp_float("R10 early link idle not release");
    lnk_ctl = 2'b01;
    exp_float("R10 hold");
    lnk_ctl = 2'b10; rx_on = 1'b1;
    exp_float("R10 rx ignored");
    rx_on = 1'b0;
    exp_float("R10 transmit");
    lnk_ctl = 2'b00;
    exp_float("R11 turnaround");
    exp_cd(2'b00, 4'h0, "R11 resume idle");
    exp_cd(2'b00, 4'h0, "R11 idle");

    // R12 hold after transmit
    arb_won = 1'b1;
    exp_cd(2'b11, 4'h0, "R9 grant");
    arb_won = 1'b0;
    exp_cd(2'b00, 4'h0, "R9 idle");
    exp_float("R9 float");
    lnk_ctl = 2'b10;
    exp_float("R12 transmit");
    lnk_ctl = 2'b01;
    exp_float("R12 hold seen");
    lnk_ctl = 2'b00;
    exp_cd(2'b11, 4'h0, "R12 regrant");
    exp_cd(2'b00, 4'h0, "R12 idle");
    exp_float("R12 float");
    lnk_ctl = 2'b10;
    exp_float("R12 transmit again");
    lnk_ctl = 2'b00;
    exp_float("R11 turnaround");
    exp_cd(2'b00, 4'h0, "R11 resume");

    // R13 precedence
    rx_on = 1'b1; arb_won = 1'b1; stat_req = 1'b1; stat_word = 16'hF00F;
    exp_cd(2'b10, 4'hF, "R13 receive first");
    rx_on = 1'b0; arb_won = 1'b0;
    exp_cd(2'b00, 4'h0, "R13 preamble abort");
    exp_cd(2'b11, 4'h0, "R13 remembered grant before status");
    exp_cd(2'b00, 4'h0, "R13 idle");
    exp_float("R13 float");
    lnk_ctl = 2'b01;
    exp_float("R13 hold");
    lnk_ctl = 2'b00;
    exp_float("R11 turnaround");
    exp_cd(2'b00, 4'h0, "R11 resume");
    send_pairs(16'hF00F, 0, "R13 status after grant");
    exp_done("R13 status done");
    stat_req = 1'b0;
    step();
    step();

    summary();
    $finish;
  end
endmodule